// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits behind the write port of a page-programmed non-volatile memory. It watches every qualified write cycle, meaning an address and a data byte, and recognises a family of multi-cycle unlock commands. All of these commands begin with the same two-byte unlock prefix. Address bits above bit 14 play no part in the match. The commands can:

- turn software write protection on and open a page-load window;
- turn software write protection off;
- request a chip erase;
- enter or leave an identification mode;
- lock either of two boot blocks.

The protection flag and the two boot-lock flags are non-volatile in behaviour. They start from fixed power-on values and are not touched by `rst_n`. The current step of a partial command, the identification mode and the load window are volatile and are cleared by `rst_n`.

The surrounding memory logic uses three registered pulses and flags. `load_ok` marks a write that must be stored into the page buffer. `erase_req` starts an erase, whose timing is handled elsewhere. `id_mode` tells the read path that identification is active. While identification is active, a combinational override returns the manufacturer and device bytes and the boot-lock status for four fixed read addresses. For every other address the override stays inactive and the array data passes through.

Top module: `cmdseq_unlock`

## Requirements
- R1: A command byte matches only on `wr_addr[14:0]` and `wr_data[7:0]`. The two command addresses are 5555h (called A) and 2AAAh (called B), so 35555h acts exactly as 5555h. Every command starts with AAh at A, then 55h at B.
- R2: After the prefix, A0h at A sets `prot_on` to 1 and opens the load window. While the window is open, every write gives `load_ok`=1 and bypasses command matching.
- R3: Each write accepted through the window restarts it. A write is accepted when its edge comes at most `LOAD_WINDOW` cycles after the previous accepted write's edge, or after the A0h edge. Once the window has closed, a non-command write under protection gives `load_ok`=0.
- R4: The prefix, then 80h@A, AAh@A, 55h@B, 20h@A, clears `prot_on` to 0.
- R5: `prot_on` powers up at `PROT_INIT` (default 1). The boot-lock flags power up at 0. None of the three changes when `rst_n` is asserted.
- R6: The prefix, then 80h@A, AAh@A, 55h@B, 10h@A, gives a single-cycle `erase_req` pulse when no boot block is locked.
- R7: The prefix, then 80h@A, AAh@A, 55h@B, 40h@A, followed by a seventh byte at A, locks a boot block. A seventh byte of 01h locks the lower block and 02h locks the upper block. While either block is locked, the erase sequence gives no `erase_req`.
- R8: The erase-style sequence ending in 60h@A sets `id_mode`. The prefix followed by F0h@A clears it. `rst_n` also clears it.
- R9: With `id_mode`=1, `ovr_valid`=1 and `ovr_data` returns a fixed byte for four read addresses:
  - 00000h returns DAh;
  - 00001h returns 45h;
  - 00002h reports the lower boot block;
  - 3FFF2h reports the upper boot block.
  A boot-block read returns FFh when the block is locked and FEh when it is unlocked. Every other address, and any read with `id_mode`=0, gives `ovr_valid`=0.
- R10: A byte that is not the expected next step sends the matcher back to idle. That byte gives `load_ok`=1 when protection is off and is dropped when protection is on. Bytes already consumed by an abandoned partial command are never loaded.
- R11: With protection off, a write that does not start or continue a command gives `load_ok`=1.
- R12: `load_ok` and `erase_req` are high for exactly the one cycle after the write's clock edge. `prot_on` and `id_mode` take their new value in that same cycle. The read override follows `rd_addr` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the volatile state |
| wr_valid | input | 1 | One qualified write cycle this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Current read address, for the override |
| prot_on | output | 1 | Software write protection active |
| load_ok | output | 1 | Pulse: the last write goes into the page buffer |
| erase_req | output | 1 | Pulse: start a chip erase |
| id_mode | output | 1 | Identification mode active |
| ovr_valid | output | 1 | `ovr_data` replaces array read data |
| ovr_data | output | 8 | Identification or boot-lock status byte |

## Verification
Two functions can fall in the same cycle: the expiry of the load window and the arrival of a new write. In that cycle the write must win, be loaded, and re-arm the window.

The bench provokes this in two steps. It first spaces two writes exactly `LOAD_WINDOW` cycles apart, which must be accepted. It then spaces two writes one cycle further apart, which must be rejected under protection.

Both outcomes are judged by a behavioural model that keeps a queue of pending command bytes and a window countdown, and is compared with every output on every clock. Directed checks repeat the verdict at the port.

A second coincidence is a boot-block read while identification mode is being left. The override must drop on the same cycle that `id_mode` falls.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

  localparam int CMP_W = 15;

  localparam logic [CMP_W-1:0] ADR_A = 15'h5555;
  localparam logic [CMP_W-1:0] ADR_B = 15'h2AAA;

  localparam logic [7:0] CD_UNL1    = 8'hAA;
  localparam logic [7:0] CD_UNL2    = 8'h55;
  localparam logic [7:0] CD_PROT    = 8'hA0;
  localparam logic [7:0] CD_EXTEND  = 8'h80;
  localparam logic [7:0] CD_ID_EXIT = 8'hF0;
  localparam logic [7:0] CD_UNPROT  = 8'h20;
  localparam logic [7:0] CD_ERASE   = 8'h10;
  localparam logic [7:0] CD_ID_ENT  = 8'h60;
  localparam logic [7:0] CD_LOCK    = 8'h40;
  localparam logic [7:0] CD_LOCK_LO = 8'h01;
  localparam logic [7:0] CD_LOCK_HI = 8'h02;

  localparam logic [7:0] ID_MFR     = 8'hDA;
  localparam logic [7:0] ID_DEV     = 8'h45;
  localparam logic [7:0] ST_LOCKED  = 8'hFF;
  localparam logic [7:0] ST_OPEN    = 8'hFE;

  localparam int NUM_BOOT = 2;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PRE1,
    SQ_PRE2,
    SQ_EXT0,
    SQ_EXT1,
    SQ_EXT2,
    SQ_LOCK
  } step_e;

  typedef struct packed {
    logic                protect;
    logic                unprotect;
    logic                erase;
    logic                id_enter;
    logic                id_exit;
    logic [NUM_BOOT-1:0] lock;
    logic                mismatch;
  } cmd_ev_t;

  function automatic logic cmd_hit(input logic [CMP_W-1:0] a, input logic [7:0] d,
                                   input logic [CMP_W-1:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic logic [7:0] lock_status(input logic locked);
    return locked ? ST_LOCKED : ST_OPEN;
  endfunction

endpackage

// File: rtl/cmdseq_matcher.sv
module cmdseq_matcher
  import cmdseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CMP_W-1:0] cadr,
  input  logic [7:0]       cdat,
  output cmd_ev_t          ev,
  output step_e            step
);

  step_e step_q, step_d;
  logic  at_a;

  assign at_a = (cadr == ADR_A);

  always_comb begin
    step_d = step_q;
    ev     = '0;
    if (take) begin
      step_d = SQ_IDLE;
      unique case (step_q)
        SQ_IDLE: begin
          if (cmd_hit(cadr, cdat, ADR_A, CD_UNL1)) step_d = SQ_PRE1;
          else ev.mismatch = 1'b1;
        end
        SQ_PRE1: begin
          if (cmd_hit(cadr, cdat, ADR_B, CD_UNL2)) step_d = SQ_PRE2;
          else ev.mismatch = 1'b1;
        end
        SQ_PRE2: begin
          if (!at_a) ev.mismatch = 1'b1;
          else begin
            case (cdat)
              CD_PROT:    ev.protect = 1'b1;
              CD_ID_EXIT: ev.id_exit = 1'b1;
              CD_EXTEND:  step_d     = SQ_EXT0;
              default:    ev.mismatch = 1'b1;
            endcase
          end
        end
        SQ_EXT0: begin
          if (cmd_hit(cadr, cdat, ADR_A, CD_UNL1)) step_d = SQ_EXT1;
          else ev.mismatch = 1'b1;
        end
        SQ_EXT1: begin
          if (cmd_hit(cadr, cdat, ADR_B, CD_UNL2)) step_d = SQ_EXT2;
          else ev.mismatch = 1'b1;
        end
        SQ_EXT2: begin
          if (!at_a) ev.mismatch = 1'b1;
          else begin
            case (cdat)
              CD_UNPROT: ev.unprotect = 1'b1;
              CD_ERASE:  ev.erase     = 1'b1;
              CD_ID_ENT: ev.id_enter  = 1'b1;
              CD_LOCK:   step_d       = SQ_LOCK;
              default:   ev.mismatch  = 1'b1;
            endcase
          end
        end
        SQ_LOCK: begin
          if (!at_a) ev.mismatch = 1'b1;
          else begin
            case (cdat)
              CD_LOCK_LO: ev.lock[0] = 1'b1;
              CD_LOCK_HI: ev.lock[1] = 1'b1;
              default:    ev.mismatch = 1'b1;
            endcase
          end
        end
        default: ev.mismatch = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= SQ_IDLE;
    else        step_q <= step_d;
  end

  assign step = step_q;

endmodule

// File: rtl/cmdseq_load_window.sv
module cmdseq_load_window #(
  parameter int LOAD_WINDOW = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic wr,
  output logic open
);

  localparam int CW = $clog2(LOAD_WINDOW + 1);
  localparam logic [CW-1:0] RELOAD = CW'(LOAD_WINDOW);

  logic [CW-1:0] left_q;

  assign open = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                left_q <= '0;
    else if (arm || (wr && open)) left_q <= RELOAD;
    else if (open)             left_q <= left_q - 1'b1;
  end

endmodule

// File: rtl/cmdseq_id_readback.sv
module cmdseq_id_readback
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic                id_mode,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [NUM_BOOT-1:0] lock,
  output logic                ovr_valid,
  output logic [7:0]          ovr_data
);

  localparam logic [ADDR_W-1:0] AD_MFR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] AD_DEV  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] AD_LOW  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] AD_HIGH = {ADDR_W{1'b1}} - ADDR_W'(13);

  logic [NUM_BOOT-1:0] blk_hit;
  logic [7:0]          blk_byte [NUM_BOOT];

  for (genvar b = 0; b < NUM_BOOT; b++) begin : g_blk
    assign blk_hit[b]  = (rd_addr == ((b == 0) ? AD_LOW : AD_HIGH));
    assign blk_byte[b] = lock_status(lock[b]);
  end

  always_comb begin
    ovr_valid = 1'b0;
    ovr_data  = 8'h00;
    if (id_mode) begin
      if (rd_addr == AD_MFR) begin
        ovr_valid = 1'b1;
        ovr_data  = ID_MFR;
      end else if (rd_addr == AD_DEV) begin
        ovr_valid = 1'b1;
        ovr_data  = ID_DEV;
      end else begin
        for (int b = 0; b < NUM_BOOT; b++) begin
          if (blk_hit[b]) begin
            ovr_valid = 1'b1;
            ovr_data  = blk_byte[b];
          end
        end
      end
    end
  end

endmodule

// File: rtl/cmdseq_unlock.sv
module cmdseq_unlock
  import cmdseq_pkg::*;
#(
  parameter int   ADDR_W      = 18,
  parameter int   LOAD_WINDOW = 20000,
  parameter logic PROT_INIT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prot_on,
  output logic              load_ok,
  output logic              erase_req,
  output logic              id_mode,
  output logic              ovr_valid,
  output logic [7:0]        ovr_data
);

  cmd_ev_t ev;
  step_e   step;

  logic win_open;
  logic take;
  logic load_now;
  logic any_lock;

  logic ev_protect, ev_unprotect, ev_erase, ev_id_enter, ev_id_exit, ev_mismatch;
  logic [NUM_BOOT-1:0] ev_lock;
  logic [NUM_BOOT+5:0] ev_vec;

  logic                prot_q = PROT_INIT;
  logic [NUM_BOOT-1:0] lock_q;
  logic                id_q, load_q, erase_q;

  assign take = wr_valid && !win_open;

  cmdseq_matcher u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .cadr  (wr_addr[CMP_W-1:0]),
    .cdat  (wr_data),
    .ev    (ev),
    .step  (step)
  );

  assign ev_protect   = ev.protect;
  assign ev_unprotect = ev.unprotect;
  assign ev_erase     = ev.erase;
  assign ev_id_enter  = ev.id_enter;
  assign ev_id_exit   = ev.id_exit;
  assign ev_lock      = ev.lock;
  assign ev_mismatch  = ev.mismatch;
  assign ev_vec       = ev;

  cmdseq_load_window #(.LOAD_WINDOW(LOAD_WINDOW)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (ev_protect),
    .wr    (wr_valid),
    .open  (win_open)
  );

  always_ff @(posedge clk) begin
    if (ev_protect)        prot_q <= 1'b1;
    else if (ev_unprotect) prot_q <= 1'b0;
  end

  for (genvar b = 0; b < NUM_BOOT; b++) begin : g_lock
    logic flag_q = 1'b0;
    always_ff @(posedge clk) begin
      if (ev_lock[b]) flag_q <= 1'b1;
    end
    assign lock_q[b] = flag_q;
  end

  assign any_lock = |lock_q;
  assign load_now = wr_valid && (win_open || (ev_mismatch && !prot_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q    <= 1'b0;
      load_q  <= 1'b0;
      erase_q <= 1'b0;
    end else begin
      load_q  <= load_now;
      erase_q <= ev_erase && !any_lock;
      if (ev_id_enter)     id_q <= 1'b1;
      else if (ev_id_exit) id_q <= 1'b0;
    end
  end

  cmdseq_id_readback #(.ADDR_W(ADDR_W)) u_idrd (
    .id_mode   (id_q),
    .rd_addr   (rd_addr),
    .lock      (lock_q),
    .ovr_valid (ovr_valid),
    .ovr_data  (ovr_data)
  );

  assign prot_on   = prot_q;
  assign load_ok   = load_q;
  assign erase_req = erase_q;
  assign id_mode   = id_q;

endmodule

// File: rtl/cmdseq_unlock_chk.sv
module cmdseq_unlock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prot_on,
  input logic       load_ok,
  input logic       erase_req,
  input logic       id_mode,
  input logic       ovr_valid,
  input logic       win_open,
  input logic       any_lock,
  input logic       ev_protect,
  input logic       ev_unprotect,
  input logic       ev_erase,
  input logic       ev_id_exit,
  input logic [7:0] ev_vec
);

  AST_PROT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_protect |=> (prot_on && win_open)); // R2

  AST_PROT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unprotect |=> !prot_on); // R4

  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_protect || ev_unprotect) |=> $stable(prot_on)); // R5

  AST_ERASE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> $past(ev_erase)); // R6

  AST_ERASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> !any_lock); // R7

  AST_ID_EXIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> $past(ev_id_exit)); // R8

  AST_OVR_NEEDS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_valid |-> id_mode); // R9

  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |-> $past(win_open || !prot_on)); // R10

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_vec)); // R10

endmodule

bind cmdseq_unlock cmdseq_unlock_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .prot_on      (prot_on),
  .load_ok      (load_ok),
  .erase_req    (erase_req),
  .id_mode      (id_mode),
  .ovr_valid    (ovr_valid),
  .win_open     (win_open),
  .any_lock     (any_lock),
  .ev_protect   (ev_protect),
  .ev_unprotect (ev_unprotect),
  .ev_erase     (ev_erase),
  .ev_id_exit   (ev_id_exit),
  .ev_vec       (ev_vec)
);

// File: tb/tb_cmdseq_unlock.sv
module tb_cmdseq_unlock;

  localparam int AW  = 18;
  localparam int WIN = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          prot_on, load_ok, erase_req, id_mode, ovr_valid;
  logic [7:0]    ovr_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  cmdseq_unlock #(.ADDR_W(AW), .LOAD_WINDOW(WIN), .PROT_INIT(1'b1)) dut (
    .clk, .rst_n, .wr_valid, .wr_addr, .wr_data, .rd_addr,
    .prot_on, .load_ok, .erase_req, .id_mode, .ovr_valid, .ovr_data
  );

  // ---------------- behavioural reference model ----------------
  logic [22:0] ct [7][7];
  int          cl [7];
  logic [22:0] mq [$];
  bit m_prot = 1, m_id = 0, m_load = 0, m_erase = 0;
  bit m_lk [2] = '{0, 0};
  int m_win = 0;

  function automatic logic [22:0] pk(input logic [14:0] a, input logic [7:0] d);
    return {a, d};
  endfunction

  initial begin
    logic [22:0] pre [5];
    logic [7:0]  tail6 [4];
    pre = '{pk(15'h5555, 8'hAA), pk(15'h2AAA, 8'h55), pk(15'h5555, 8'h80),
            pk(15'h5555, 8'hAA), pk(15'h2AAA, 8'h55)};
    tail6 = '{8'h20, 8'h10, 8'h60, 8'h40};
    // 0 protect, 1 id exit, 2 unprotect, 3 erase, 4 id enter, 5 lock low, 6 lock high
    ct[0][0] = pre[0]; ct[0][1] = pre[1]; ct[0][2] = pk(15'h5555, 8'hA0); cl[0] = 3;
    ct[1][0] = pre[0]; ct[1][1] = pre[1]; ct[1][2] = pk(15'h5555, 8'hF0); cl[1] = 3;
    for (int k = 2; k < 7; k++) begin
      for (int i = 0; i < 5; i++) ct[k][i] = pre[i];
      ct[k][5] = pk(15'h5555, tail6[(k > 5) ? 3 : k - 2]);
      cl[k] = (k >= 5) ? 7 : 6;
    end
    ct[5][6] = pk(15'h5555, 8'h01);
    ct[6][6] = pk(15'h5555, 8'h02);
  end

  always @(posedge clk) begin
    int  full;
    bit  anyp, ok;
    if (!rst_n) begin
      m_id = 0; m_win = 0; m_load = 0; m_erase = 0; mq.delete();
    end else begin
      m_load = 0; m_erase = 0;
      if (wr_valid && m_win > 0) begin
        m_load = 1; m_win = WIN;
      end else if (wr_valid) begin
        mq.push_back(pk(wr_addr[14:0], wr_data));
        full = -1; anyp = 0;
        for (int k = 0; k < 7; k++) begin
          if (mq.size() <= cl[k]) begin
            ok = 1;
            for (int i = 0; i < mq.size(); i++) if (mq[i] != ct[k][i]) ok = 0;
            if (ok) begin
              anyp = 1;
              if (mq.size() == cl[k]) full = k;
            end
          end
        end
        if (full >= 0) begin
          case (full)
            0: begin m_prot = 1; m_win = WIN; end
            1: m_id = 0;
            2: m_prot = 0;
            3: m_erase = !(m_lk[0] || m_lk[1]);
            4: m_id = 1;
            5: m_lk[0] = 1;
            default: m_lk[1] = 1;
          endcase
          mq.delete();
        end else if (!anyp) begin
          m_load = !m_prot;
          mq.delete();
        end
      end else if (m_win > 0) begin
        m_win = m_win - 1;
      end
    end
  end

  function automatic int exp_ovr(input logic [AW-1:0] a);
    if (!m_id) return -1;
    if (a == 18'h00000) return 'hDA;
    if (a == 18'h00001) return 'h45;
    if (a == 18'h00002) return m_lk[0] ? 'hFF : 'hFE;
    if (a == 18'h3FFF2) return m_lk[1] ? 'hFF : 'hFE;
    return -1;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model (R12 timing)
  always @(negedge clk) begin
    int e;
    #1;
    if (rst_n && !done) begin
      chk("R12 prot_on vs model", prot_on, m_prot);
      chk("R12 load_ok vs model", load_ok, m_load);
      chk("R12 erase_req vs model", erase_req, m_erase);
      chk("R12 id_mode vs model", id_mode, m_id);
      e = exp_ovr(rd_addr);
      chk("R9 ovr_valid vs model", ovr_valid, (e >= 0) ? 1 : 0);
      if (e >= 0) chk("R9 ovr_data vs model", ovr_data, e);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    #2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); rd_addr = a; #2;
  endtask

  task automatic prefix();
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55);
  endtask

  task automatic long_cmd(input logic [7:0] last);
    prefix(); wr(18'h05555, 8'h80);
    prefix(); wr(18'h05555, last);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R5 prot_on powers up set", prot_on, 1);
    chk("R8 id_mode clear after reset", id_mode, 0);
    chk("R12 load_ok idle after reset", load_ok, 0);

    wr(18'h01234, 8'h5A);
    chk("R10 protected stray write dropped", load_ok, 0);

    // protect-and-load, with upper address bits set (R1)
    wr(18'h35555, 8'hAA); wr(18'h3AAAA, 8'h55);
    chk("R10 command byte not loaded", load_ok, 0);
    wr(18'h25555, 8'hA0);
    chk("R2 protection set", prot_on, 1);
    wr(18'h00100, 8'h11);
    chk("R2 load in window", load_ok, 1);
    idle(WIN - 2);
    wr(18'h00101, 8'h12);
    chk("R3 load at last window cycle", load_ok, 1);
    idle(WIN - 1);
    wr(18'h00102, 8'h13);
    chk("R3 write after window closes dropped", load_ok, 0);

    long_cmd(8'h20);
    chk("R4 protection cleared", prot_on, 0);
    wr(18'h00200, 8'h77);
    chk("R11 unprotected plain write loads", load_ok, 1);

    pulse_reset();
    chk("R5 prot_on survives reset", prot_on, 0);

    prefix();
    chk("R10 prefix byte not loaded", load_ok, 0);
    wr(18'h01000, 8'h33);
    chk("R10 mismatch byte forwarded", load_ok, 1);
    wr(18'h02AAA, 8'h55);
    chk("R10 matcher back at idle", load_ok, 1);

    long_cmd(8'h60);
    chk("R8 id entry", id_mode, 1);
    rd(18'h00000); chk("R9 manufacturer byte", ovr_data, 'hDA);
    rd(18'h00001); chk("R9 device byte", ovr_data, 'h45);
    rd(18'h00002); chk("R9 lower block open", ovr_data, 'hFE);
    rd(18'h3FFF2); chk("R9 upper block open", ovr_data, 'hFE);
    rd(18'h00005); chk("R9 no override elsewhere", ovr_valid, 0);

    long_cmd(8'h10);
    chk("R6 erase request", erase_req, 1);
    idle(1);
    chk("R6 erase pulse one cycle", erase_req, 0);

    long_cmd(8'h40); wr(18'h05555, 8'h01);
    rd(18'h00002); chk("R7 lower block locked", ovr_data, 'hFF);
    rd(18'h3FFF2); chk("R7 upper block still open", ovr_data, 'hFE);
    long_cmd(8'h10);
    chk("R7 erase blocked by lock", erase_req, 0);

    rd(18'h00002);
    prefix(); wr(18'h05555, 8'hF0);
    chk("R8 id exit", id_mode, 0);
    chk("R9 override off outside id", ovr_valid, 0);

    long_cmd(8'h60);
    pulse_reset();
    chk("R8 reset clears id", id_mode, 0);
    long_cmd(8'h60);
    rd(18'h00002); chk("R5 lock survives reset", ovr_data, 'hFF);
    long_cmd(8'h40); wr(18'h15555, 8'h02);
    rd(18'h3FFF2); chk("R7 upper block locked", ovr_data, 'hFF);
    prefix(); wr(18'h05555, 8'hF0);

    prefix(); wr(18'h05555, 8'hA0);
    chk("R2 protect again", prot_on, 1);
    idle(WIN + 2);
    wr(18'h00300, 8'h44);
    chk("R3 protected after window", load_ok, 0);
    idle(3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(1_000_000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule